// File: doc/BRIEF.md
# Interrupt Priority Register Bank and Arbiter

This block holds a five-bit priority for each of 112 interrupt lines. It also picks, on every clock, the most urgent interrupt among the lines that are both pending and enabled. Software reaches the priorities through 32-bit word registers. Each word packs the fields of four consecutive interrupts into its four byte lanes. A write carries byte strobes, so one field can change without touching its three neighbours. Only the upper five bits of each byte are kept; the three low bits read as zero. Word indices past the last populated word read as zero and drop writes.

On the arbitration side, a 112-bit vector marks the candidate lines. A balanced comparison tree finds the candidate with the numerically smallest priority. When priorities are equal, the lower interrupt number wins. The winner's number, its priority and a valid flag are registered, so the result reflects the inputs and stored priorities one clock earlier. Grouping, preemption, pending-state handling and privilege checks belong to the surrounding controller and are not part of this block.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset every stored priority is zero, so any word read returns 0, and `win_valid` is low.
- R2: The priority of interrupt N lives in word index N/4 (integer division), in byte lane N%4. Lane L occupies data bits [8L+7:8L].
- R3: Each byte field stores only its bits 7:3 as a priority of 0 to 31. Bits 2:0 of every field always read 0, and values written to them have no effect.
- R4: A write updates only the lanes whose strobe bit is set; bit L of `reg_be` selects lane L. A write with no strobe set changes nothing.
- R5: Word indices 28 and above read as 0, and writes to them change no stored priority.
- R6: When at least one `req_vec` bit is set, `win_id` names a set bit whose priority is the numerically smallest among all set bits, and `win_prio` is that priority.
- R7: Among candidates with equal best priority, the lowest interrupt number wins.
- R8: When no `req_vec` bit is set, `win_valid` is 0 and `win_id` and `win_prio` are 0.
- R9: The winner outputs reflect `req_vec` and the stored priorities as they were one clock edge earlier. A priority written at edge k affects the outputs from edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 6 | Word index of the register access |
| reg_wen | input | 1 | Write enable for the addressed word |
| reg_wdata | input | 32 | Write data, four byte lanes |
| reg_be | input | 4 | Byte-lane strobes, bit L for lane L |
| reg_rdata | output | 32 | Read data of the addressed word (combinational) |
| req_vec | input | 112 | Pending-and-enabled flag per interrupt |
| win_valid | output | 1 | A candidate exists (registered) |
| win_id | output | 7 | Number of the winning interrupt (registered) |
| win_prio | output | 5 | Priority of the winning interrupt (registered) |

## Verification
Some rules are checked on every cycle. The low three bits of each read lane must be zero, and out-of-range words must read zero. A write to an out-of-range word, or one with no strobes, must leave the whole bank unchanged. The valid flag must track whether the previous cycle had any request, and a reported winner must have been requested in that cycle. With no winner, the number and priority must read zero. Other behaviour needs the bench's scenarios: which candidate is the true minimum, how ties break by number, the field-to-lane mapping, the merge of a partial strobe, and the one-cycle delay after a priority write.

// File: rtl/irqprio_pkg.sv
package irqprio_pkg;

  // Word index holding the field of interrupt n.
  function automatic int unsigned word_of(input int unsigned n, input int unsigned lanes);
    return n / lanes;
  endfunction

  // Byte lane within that word.
  function automatic int unsigned lane_of(input int unsigned n, input int unsigned lanes);
    return n % lanes;
  endfunction

  // Tree merge rule: keep side A (lower numbers) unless B is strictly more urgent.
  function automatic logic keep_a(input logic a_v, input int unsigned a_p,
                                  input logic b_v, input int unsigned b_p);
    return a_v && (!b_v || (a_p <= b_p));
  endfunction

endpackage

// File: rtl/irqprio_bank.sv
module irqprio_bank #(
  parameter int NUM_IRQ = 112,
  parameter int PRIO_W  = 5,
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int FIELD_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic                      wr_en,
  input  logic [LANES*FIELD_W-1:0]  wr_data,
  input  logic [LANES-1:0]          wr_be,
  output logic [NUM_IRQ*PRIO_W-1:0] prio_flat
);
  import irqprio_pkg::*;

  localparam int NUM_WORDS = (NUM_IRQ + LANES - 1) / LANES;

  // Named events for the checks below.
  logic wr_oob;
  logic wr_nolane;
  assign wr_oob    = wr_en && (int'(wr_addr) >= NUM_WORDS);
  assign wr_nolane = wr_en && (wr_be == '0);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_field
    localparam int WORD = int'(word_of(i, LANES));
    localparam int LANE = int'(lane_of(i, LANES));
    logic              hit;
    logic [PRIO_W-1:0] val_q;
    assign hit = wr_en && (int'(wr_addr) == WORD) && wr_be[LANE];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q <= '0;
      else if (hit) val_q <= wr_data[LANE*FIELD_W + FIELD_W - 1 -: PRIO_W];
    end
    assign prio_flat[i*PRIO_W +: PRIO_W] = val_q;
  end

  p_oob_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_oob |=> $stable(prio_flat));

  p_no_strobe_no_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_nolane |=> $stable(prio_flat));

endmodule

// File: rtl/irqprio_rdmux.sv
module irqprio_rdmux #(
  parameter int NUM_IRQ = 112,
  parameter int PRIO_W  = 5,
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int FIELD_W = 8
) (
  input  logic [ADDR_W-1:0]         rd_addr,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
  output logic [LANES*FIELD_W-1:0]  rd_data
);
  localparam int NUM_WORDS = (NUM_IRQ + LANES - 1) / LANES;
  localparam int PAD_W     = FIELD_W - PRIO_W;

  always_comb begin
    rd_data = '0;
    for (int l = 0; l < LANES; l++) begin
      int idx;
      idx = int'(rd_addr) * LANES + l;
      if ((int'(rd_addr) < NUM_WORDS) && (idx < NUM_IRQ))
        rd_data[l*FIELD_W +: FIELD_W] = {prio_flat[idx*PRIO_W +: PRIO_W], {PAD_W{1'b0}}};
    end
  end

endmodule

// File: rtl/irqprio_tree.sv
module irqprio_tree #(
  parameter int NUM_IRQ = 112,
  parameter int PRIO_W  = 5,
  parameter int ID_W    = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0]        cand,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
  output logic                      best_v,
  output logic [ID_W-1:0]           best_id,
  output logic [PRIO_W-1:0]         best_p
);
  import irqprio_pkg::*;

  localparam int LEAVES = 1 << ID_W;
  localparam int NODES  = 2 * LEAVES - 1;

  // Heap layout: node j has children 2j+1 (lower numbers) and 2j+2.
  logic              nv [NODES];
  logic [ID_W-1:0]   nid[NODES];
  logic [PRIO_W-1:0] np [NODES];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < NUM_IRQ) begin : g_real
      assign nv [LEAVES-1+i] = cand[i];
      assign nid[LEAVES-1+i] = cand[i] ? ID_W'(i) : '0;
      assign np [LEAVES-1+i] = cand[i] ? prio_flat[i*PRIO_W +: PRIO_W] : '0;
    end else begin : g_pad
      assign nv [LEAVES-1+i] = 1'b0;
      assign nid[LEAVES-1+i] = '0;
      assign np [LEAVES-1+i] = '0;
    end
  end

  for (genvar j = 0; j < LEAVES - 1; j++) begin : g_node
    logic take_l;
    assign take_l = keep_a(nv[2*j+1], int'(np[2*j+1]), nv[2*j+2], int'(np[2*j+2]));
    assign nv [j] = nv[2*j+1] | nv[2*j+2];
    assign nid[j] = take_l ? nid[2*j+1] : nid[2*j+2];
    assign np [j] = take_l ? np [2*j+1] : np [2*j+2];
  end

  assign best_v  = nv[0];
  assign best_id = nid[0];
  assign best_p  = np[0];

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter #(
  parameter int NUM_IRQ = 112,
  parameter int PRIO_W  = 5,
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int FIELD_W = 8,
  parameter int ID_W    = $clog2(NUM_IRQ)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic                     reg_wen,
  input  logic [LANES*FIELD_W-1:0] reg_wdata,
  input  logic [LANES-1:0]         reg_be,
  output logic [LANES*FIELD_W-1:0] reg_rdata,
  input  logic [NUM_IRQ-1:0]       req_vec,
  output logic                     win_valid,
  output logic [ID_W-1:0]          win_id,
  output logic [PRIO_W-1:0]        win_prio
);
  localparam int NUM_WORDS = (NUM_IRQ + LANES - 1) / LANES;
  localparam int PAD_W     = FIELD_W - PRIO_W;

  logic [NUM_IRQ*PRIO_W-1:0] prio_flat;
  logic                      best_v;
  logic [ID_W-1:0]           best_id;
  logic [PRIO_W-1:0]         best_p;

  irqprio_bank #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W),
                 .LANES(LANES), .FIELD_W(FIELD_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_addr(reg_addr), .wr_en(reg_wen),
    .wr_data(reg_wdata), .wr_be(reg_be), .prio_flat(prio_flat));

  irqprio_rdmux #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W),
                  .LANES(LANES), .FIELD_W(FIELD_W)) u_rdmux (
    .rd_addr(reg_addr), .prio_flat(prio_flat), .rd_data(reg_rdata));

  irqprio_tree #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_tree (
    .cand(req_vec), .prio_flat(prio_flat),
    .best_v(best_v), .best_id(best_id), .best_p(best_p));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_valid <= 1'b0;
      win_id    <= '0;
      win_prio  <= '0;
    end else begin
      win_valid <= best_v;
      win_id    <= best_id;
      win_prio  <= best_p;
    end
  end

  // ---------------- checks ----------------
  // live_q: at least one edge has passed since reset, so $past is meaningful.
  logic live_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  logic [LANES*FIELD_W-1:0] low_mask;
  always_comb begin
    low_mask = '0;
    for (int l = 0; l < LANES; l++) low_mask[l*FIELD_W +: PAD_W] = {PAD_W{1'b1}};
  end

  logic               rd_oob;
  logic [NUM_IRQ-1:0] win_onehot;
  assign rd_oob     = int'(reg_addr) >= NUM_WORDS;
  assign win_onehot = {{(NUM_IRQ-1){1'b0}}, 1'b1} << win_id;

  p_low_bits_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & low_mask) == '0);

  p_oob_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oob |-> reg_rdata == '0);

  p_valid_tracks_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (win_valid == $past(|req_vec)));

  p_winner_requested_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && win_valid) |-> (($past(req_vec) & win_onehot) != '0));

  p_winner_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (int'(win_id) < NUM_IRQ));

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |-> (win_id == '0 && win_prio == '0));

endmodule

// File: tb/irq_prio_arbiter_tb.sv
module irq_prio_arbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NIRQ = 112;
  localparam int NWORDS = 28;
  localparam logic [6:0] NONE = 7'd127;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [5:0]   reg_addr = '0;
  logic         reg_wen = 1'b0;
  logic [31:0]  reg_wdata = '0;
  logic [3:0]   reg_be = '0;
  logic [31:0]  reg_rdata;
  logic [NIRQ-1:0] req_vec = '0;
  logic         win_valid;
  logic [6:0]   win_id;
  logic [4:0]   win_prio;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata),
    .req_vec(req_vec), .win_valid(win_valid), .win_id(win_id), .win_prio(win_prio));

  // Chosen priority pattern: 31 minus (n mod 32); numbers 32 apart tie.
  function automatic logic [4:0] pat(input int n);
    return 5'(31 - (n % 32));
  endfunction

  // Expected word (R2, R3): lane L of word w holds pat(4w+L) in bits 7:3.
  function automatic logic [31:0] exp_word(input int w);
    logic [31:0] v = '0;
    for (int l = 0; l < 4; l++) v[8*l +: 8] = {pat(4*w + l), 3'b000};
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    reg_addr = 6'(a); reg_wdata = d; reg_be = be; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0; reg_be = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = 6'(a);
    #1 d = reg_rdata;
  endtask

  task automatic chk_win(input string tag, input logic v, input logic [6:0] id, input logic [4:0] p);
    chk({tag, " valid"}, 32'(win_valid), 32'(v));
    chk({tag, " id"},    32'(win_id),    32'(id));
    chk({tag, " prio"},  32'(win_prio),  32'(p));
  endtask

  // Vectors: up to three requested numbers (127 = none), expected valid, id, prio.
  localparam logic [33:0] TBL [0:7] = '{
    {7'd5,   7'd127, 7'd127, 1'b1, 7'd5,  5'd26},  // single candidate (R6)
    {7'd10,  7'd20,  7'd127, 1'b1, 7'd20, 5'd11},  // higher number more urgent (R6)
    {7'd35,  7'd3,   7'd127, 1'b1, 7'd3,  5'd28},  // tie 3 vs 35 (R7)
    {7'd100, 7'd63,  7'd31,  1'b1, 7'd31, 5'd0},   // tie at 0, 31 vs 63 (R7)
    {7'd111, 7'd0,   7'd127, 1'b1, 7'd111,5'd16},  // top number wins (R6)
    {7'd127, 7'd127, 7'd127, 1'b0, 7'd0,  5'd0},   // nothing pending (R8)
    {7'd95,  7'd64,  7'd127, 1'b1, 7'd95, 5'd0},   // R6
    {7'd127, 7'd49,  7'd50,  1'b1, 7'd50, 5'd13}   // R6
  };

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(3, d);  chk("R1 word3 after reset", d, 32'h0);
    rd(27, d); chk("R1 word27 after reset", d, 32'h0);
    chk_win("R1 idle winner", 1'b0, 7'd0, 5'd0);

    // Load all words with low bits set to garbage (R3)
    for (int w = 0; w < NWORDS; w++) wr(w, exp_word(w) | 32'h0707_0707, 4'hF);

    // R2, R3: readback of every word
    for (int w = 0; w < NWORDS; w++) begin
      rd(w, d); chk($sformatf("R2 R3 readback word %0d", w), d, exp_word(w));
    end

    // Table walk: R6, R7, R8, R9
    for (int k = 0; k < 8; k++) begin
      logic [6:0] a, b, c;
      {a, b, c} = TBL[k][33:13];
      @(negedge clk);
      req_vec = '0;
      if (a != NONE) req_vec[a] = 1'b1;
      if (b != NONE) req_vec[b] = 1'b1;
      if (c != NONE) req_vec[c] = 1'b1;
      @(negedge clk);
      chk_win($sformatf("R6 R7 R8 vector %0d", k), TBL[k][12], TBL[k][11:5], TBL[k][4:0]);
    end

    // R9: request latency
    @(negedge clk); req_vec = '0;
    @(negedge clk);
    req_vec[40] = 1'b1;
    #1 chk("R9 no change before edge", 32'(win_valid), 32'd0);
    @(negedge clk);
    chk_win("R9 request after one edge", 1'b1, 7'd40, 5'd23);

    // R9: priority write latency (irq 40 = word 10 lane 0 -> prio 2)
    reg_addr = 6'd10; reg_wdata = 32'h0000_0010; reg_be = 4'b0001; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0; reg_be = '0;
    chk("R9 old prio at write edge", 32'(win_prio), 32'd23);
    @(negedge clk);
    chk("R9 new prio one edge later", 32'(win_prio), 32'd2);

    // R4: single-lane strobe on word 2 (irq 10 -> 31)
    wr(2, 32'hFFFF_FFFF, 4'b0100);
    rd(2, d); chk("R4 lane2 only", d, {8'hF8 & 8'hF8, 8'hF8, 8'hB0, 8'hB8} & 32'h00FF_FFFF | {exp_word(2)[31:24], 24'h0});
    rd(2, d); chk("R4 other lanes kept", d & 32'hFF00_FFFF, exp_word(2) & 32'hFF00_FFFF);
    @(negedge clk); req_vec = '0; req_vec[10] = 1'b1;
    @(negedge clk); chk_win("R4 updated prio seen by arbiter", 1'b1, 7'd10, 5'd31);

    // R4: no strobes
    wr(5, 32'hFFFF_FFFF, 4'b0000);
    rd(5, d); chk("R4 empty strobe", d, exp_word(5));

    // R5: out-of-range words
    wr(28, 32'hFFFF_FFFF, 4'hF);
    wr(63, 32'hFFFF_FFFF, 4'hF);
    rd(28, d); chk("R5 read word 28", d, 32'h0);
    rd(63, d); chk("R5 read word 63", d, 32'h0);
    begin
      int bad = 0;
      for (int w = 0; w < NWORDS; w++) begin
        logic [31:0] e;
        e = exp_word(w);
        if (w == 2)  e[23:16] = 8'hF8;
        if (w == 10) e[7:0]   = 8'h10;
        rd(w, d);
        if (d !== e) bad++;
      end
      chk("R5 bank untouched by out-of-range writes", 32'(bad), 32'd0);
    end

    // R1 + R7: reset mid-run, all candidates at priority 0 -> lowest number
    @(negedge clk); rst_n = 1'b0; req_vec = '1;
    @(negedge clk);
    rd(7, d); chk("R1 word7 cleared", d, 32'h0);
    chk("R1 valid low in reset", 32'(win_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_win("R7 all equal after reset", 1'b1, 7'd0, 5'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule